// File: doc/BRIEF.md
# Programmable-Length Video Line Delay

This block delays a stream of pixel words by a number of clock cycles chosen at run time. It is meant for holding one video line so that a later stage can see the pixel above the current one. Everything runs on one clock. Each incoming word is registered and written into a circular RAM at the write pointer. An output register reads the RAM at a read pointer that trails the write pointer, and that output register drives the data port.

A length code sets the delay: a code of `c` gives a delay of `c + 2` cycles. With the default 4096-entry RAM, the delay spans 2 to 4097 cycles. The code is taken from a bus while an active-low load strobe is held low. Two active-low strobes return the write and read pointers to address 0. They are normally pulsed together to start a line. After a read-pointer clear, the read pointer waits at address 0 until the write side is exactly `c + 2` cycles ahead. Only then does the valid qualifier rise.

When the write-enable input is driven high, the block enters loop mode. Writes stop, the write pointer holds still, and the input word is ignored. The read pointer keeps stepping and runs over addresses 0 to `c + 1`, so the stored line plays back again and again. An active-low output enable forces the data output to zero and drops the valid qualifier. The pipeline keeps running underneath.

Top module: `video_line_delay`

## Requirements
- R1: The length code register loads `len_code` on a rising edge where `len_load_n` is 0. On every other edge it keeps its value, whatever `len_code` carries.
- R2: After `wptr_rst_n` and `rptr_rst_n` are both 0 on the same edge (the start edge, index 0), with `wr_en_n` held 0, the word sampled on `din` at edge index `n` appears on `dout` after edge index `n + c + 2`, where `c` is the loaded code.
- R3: After a start edge, `dout_valid` is 0 after edge indices 0 to `c + 1`. It is 1 from edge index `c + 2` onward, and the word shown there is the one sampled at the start edge.
- R4: While `wr_en_n` is 1, nothing is written and the write pointer holds still. Words on `din` are ignored, so earlier samples stay in the RAM beyond one full RAM depth of cycles. After both pointers are cleared again with `wr_en_n` at 0, R2 holds again.
- R5: In loop mode the read address steps by one each cycle and returns to 0 after address `c + 1`. The output therefore repeats the words stored at addresses 0 to `c + 1`, with period `c + 2` (capped at the RAM depth).
- R6: While `out_en_n` is 1, `dout` is all zeros and `dout_valid` is 0. The delay pipeline keeps advancing, and the correct delayed words reappear once `out_en_n` returns to 0.
- R7: Synchronous active-high `rst` clears the output word to 0, the valid qualifier to 0, both pointers to 0 and the length code to 0. With no later load, a start edge then gives the 2-cycle delay.
- R8: The largest code, the RAM depth minus one, gives a delay of the RAM depth plus one. Each word is read on the same edge that its RAM location is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Pixel word in, registered before storage |
| len_code | input | ADDR_W | Delay code; the delay is code + 2 cycles |
| len_load_n | input | 1 | Active-low strobe that loads `len_code` |
| wr_en_n | input | 1 | 0: delay mode with writes; 1: loop mode, input ignored |
| wptr_rst_n | input | 1 | Active-low clear of the write pointer to address 0 |
| rptr_rst_n | input | 1 | Active-low clear of the read pointer; restarts the fill wait |
| out_en_n | input | 1 | Active-low output enable; when high, forces `dout` to 0 |
| dout | output | DATA_W | Delayed pixel word, registered |
| dout_valid | output | 1 | High when `dout` holds a word from the current line |

## Verification
The hardest case to reach from the ports is the loop-mode check. It must show that the frozen write pointer really blocks overwrites. Loop playback looks correct for the first RAM-depth cycles even when writes continue, so the check has to run long enough to tell the two apart. The bench fills a 16-entry configuration with ten known words using a 5 code, then turns loop mode on. It keeps changing `din` for more than two RAM depths while checking every output against `(m - 7) mod 7`, computed from the edge index. Under a leaked write, the addresses in the loop would have been overwritten and those checks would fail. The bench also sweeps every code of the small configuration, including the read-while-overwritten top code.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int DEF_DATA_W = 12;
    localparam int DEF_ADDR_W = 12;

    // What the read pointer does on the coming edge
    typedef enum logic [1:0] {
        RP_CLEAR = 2'd0,   // pointer clear: back to 0, restart fill wait
        RP_HOLD  = 2'd1,   // still filling: stay at 0, count the edge
        RP_STEP  = 2'd2,   // advance by one
        RP_LOOP  = 2'd3    // loop mode end of line: back to address 0
    } rp_action_e;

    // Registered write-side control that travels with the data word
    typedef struct packed {
        logic write;   // 1 = delay mode (store), 0 = loop mode
    } wr_ctl_t;

endpackage

// File: rtl/vld_ram.sv
module vld_ram #(
    parameter int DATA_W = vld_pkg::DEF_DATA_W,
    parameter int ADDR_W = vld_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read doubles as the output register; a read to the
    // address written on the same edge returns the older word.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/vld_wr_ctrl.sv
module vld_wr_ctrl
    import vld_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en_n,
    input  logic              wptr_rst_n,
    output logic              ram_we,
    output logic [ADDR_W-1:0] wptr,
    output logic [DATA_W-1:0] wdata,
    output logic              loop_mode
);
    logic [DATA_W-1:0] din_q;
    wr_ctl_t           ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q       <= '0;
            ctl_q.write <= 1'b1;
            wptr        <= '0;
        end else begin
            din_q       <= din;
            ctl_q.write <= ~wr_en_n;
            if (!wptr_rst_n) begin
                wptr <= '0;
            end else if (ctl_q.write) begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    assign ram_we    = ctl_q.write & wptr_rst_n;
    assign wdata     = din_q;
    assign loop_mode = ~ctl_q.write;

    // R4: loop mode freezes the write pointer
    p_wptr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (wptr_rst_n && loop_mode) |=> $stable(wptr));
endmodule

// File: rtl/vld_rd_ctrl.sv
module vld_rd_ctrl
    import vld_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rptr_rst_n,
    input  logic              loop_mode,
    input  logic [ADDR_W-1:0] len_code,
    output logic [ADDR_W-1:0] rptr,
    output logic              run
);
    localparam int CW = ADDR_W + 1;

    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] lim;
    logic [CW-1:0] rptr_ext;
    rp_action_e    act;

    // lim = code + 1: last loop address, and fill edges before stepping
    assign lim      = {1'b0, len_code} + {{ADDR_W{1'b0}}, 1'b1};
    assign rptr_ext = {1'b0, rptr};

    always_comb begin
        if (!rptr_rst_n) begin
            act = RP_CLEAR;
        end else if (loop_mode) begin
            act = (rptr_ext == lim) ? RP_LOOP : RP_STEP;
        end else if (run || (hold_cnt == lim)) begin
            act = RP_STEP;
        end else begin
            act = RP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr     <= '0;
            hold_cnt <= '0;
            run      <= 1'b0;
        end else begin
            unique case (act)
                RP_CLEAR: begin
                    rptr     <= '0;
                    hold_cnt <= '0;
                    run      <= 1'b0;
                end
                RP_HOLD: begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
                RP_STEP: begin
                    rptr <= rptr + 1'b1;
                    if (!loop_mode) begin
                        run <= 1'b1;
                    end
                end
                RP_LOOP: begin
                    rptr <= '0;
                end
                default: begin
                    rptr <= rptr;
                end
            endcase
        end
    end

    // R3: a read-pointer clear always drops the run state
    p_no_valid_after_rrst_r3: assert property (@(posedge clk) disable iff (rst)
        !rptr_rst_n |=> !run);

    // R5: loop mode returns to address 0 after address code+1
    p_loop_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (rptr_rst_n && loop_mode && (rptr_ext == lim)) |=> (rptr == '0));

    // R2: once running in delay mode the read pointer steps every edge
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rptr_rst_n && !loop_mode && run) |=> (rptr == ADDR_W'($past(rptr) + 1'b1)));

    // R3: the fill counter never passes its limit while waiting
    p_hold_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (rptr_rst_n && !run && !loop_mode && (hold_cnt == lim)) |=> run);
endmodule

// File: rtl/video_line_delay.sv
module video_line_delay
    import vld_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] len_code,
    input  logic              len_load_n,
    input  logic              wr_en_n,
    input  logic              wptr_rst_n,
    input  logic              rptr_rst_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              ram_we;
    logic              loop_mode;
    logic              run;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (!len_load_n) begin
            len_q <= len_code;
        end
    end

    vld_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .wr_en_n    (wr_en_n),
        .wptr_rst_n (wptr_rst_n),
        .ram_we     (ram_we),
        .wptr       (wptr),
        .wdata      (wdata),
        .loop_mode  (loop_mode)
    );

    vld_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rptr_rst_n (rptr_rst_n),
        .loop_mode  (loop_mode),
        .len_code   (len_q),
        .rptr       (rptr),
        .run        (run)
    );

    vld_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .waddr (wptr),
        .wdata (wdata),
        .raddr (rptr),
        .rdata (rdata)
    );

    assign dout       = out_en_n ? '0 : rdata;
    assign dout_valid = run & ~out_en_n;

    // R1: the length code only changes under the load strobe
    p_len_hold_r1: assert property (@(posedge clk) disable iff (rst)
        len_load_n |=> $stable(len_q));

    // R7: reset leaves the output cleared
    p_rst_clears_r7: assert property (@(posedge clk)
        rst |=> (!dout_valid && (dout == '0)));
endmodule

// File: tb/video_line_delay_bench.sv
module video_line_delay_bench;
    localparam int DW    = 12;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] len_code = '0;
    logic          len_load_n = 1'b1;
    logic          wr_en_n = 1'b0;
    logic          wptr_rst_n = 1'b1;
    logic          rptr_rst_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    video_line_delay #(.DATA_W(DW), .ADDR_W(AW)) u_video_line_delay (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .len_code   (len_code),
        .len_load_n (len_load_n),
        .wr_en_n    (wr_en_n),
        .wptr_rst_n (wptr_rst_n),
        .rptr_rst_n (rptr_rst_n),
        .out_en_n   (out_en_n),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    function automatic logic [DW-1:0] pat(input int n, input int tag);
        return DW'((n * 37 + tag * 211 + 5) & 32'hfff);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_len(input int code, input int junk);
        @(negedge clk);
        len_code   = AW'(code);
        len_load_n = 1'b0;
        @(negedge clk);
        len_load_n = 1'b1;
        len_code   = AW'(junk);
    endtask

    // Start edge at n = 0, then stream; check valid and data every cycle
    task automatic run_delay(input int code, input int tag, input int extra,
                             input int oe_at, input string req);
        for (int n = 0; n <= code + 2 + extra; n++) begin
            @(negedge clk);
            din        = pat(n, tag);
            wr_en_n    = 1'b0;
            wptr_rst_n = (n != 0);
            rptr_rst_n = (n != 0);
            out_en_n   = (n == oe_at);
            @(posedge clk);
            #1;
            if (n == oe_at) begin
                check(dout == '0 && !dout_valid, "R6", int'(dout), 0);
            end else if (n < code + 2) begin
                check(!dout_valid, "R3", int'(dout_valid), 0);
            end else begin
                check(dout_valid, "R3", int'(dout_valid), 1);
                check(dout == pat(n - code - 2, tag), req,
                      int'(dout), int'(pat(n - code - 2, tag)));
            end
        end
        @(negedge clk);
        out_en_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dout == '0, "R7", int'(dout), 0);
        check(!dout_valid, "R7", int'(dout_valid), 0);
        @(negedge clk);
        rst = 1'b0;

        // R7: the reset length code is 0, giving a 2-cycle delay
        run_delay(0, 1, 6, -1, "R7");

        // R2 / R8: sweep every code, junk left on the bus after each load
        for (int c = 0; c < DEPTH; c++) begin
            load_len(c, DEPTH - 1 - c);
            run_delay(c, c + 10, 20, -1, (c == DEPTH - 1) ? "R8" : "R2");
        end

        // R1: the bus carries 9 with the strobe high; delay must stay 3+2
        load_len(3, 9);
        run_delay(3, 40, 8, -1, "R1");

        // R6: output enable high for one cycle mid-stream
        load_len(2, 0);
        run_delay(2, 41, 12, 10, "R2");

        // R4 / R5: code 5, fill ten words, loop for more than two depths
        load_len(5, 0);
        for (int m = 0; m <= 50; m++) begin
            @(negedge clk);
            din        = pat(m, 99);
            wr_en_n    = (m >= 10);
            wptr_rst_n = (m != 0);
            rptr_rst_n = (m != 0);
            @(posedge clk);
            #1;
            if (m >= 7) begin
                check(dout_valid, "R5", int'(dout_valid), 1);
                check(dout == pat((m - 7) % 7, 99), (m >= 28) ? "R4" : "R5",
                      int'(dout), int'(pat((m - 7) % 7, 99)));
            end
        end
        // R4: back to delay mode with a joint pointer clear
        run_delay(5, 50, 10, -1, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule